// File: doc/BRIEF.md
# Sample-Clock Generator with Sync Alignment and Runaway Monitor

This block runs from a fast master clock and produces the sample clock for a one-bit sigma-delta modulator. The sample clock is the master clock divided by four, high for two master cycles and low for two. A rising edge on the sync input restarts the divider at a fixed phase. When the divider was out of step, or when the downstream decimator has not yet been started since reset or power-down, the block also sends the decimator a one-cycle strobe that clears its filter and starts it again. While the power-down input is high, the sample clock is held low and nothing advances.

The block also takes back the one-bit stream the modulator returns. It samples one bit per sample period, on the master edge that ends the high half of the sample clock. It counts runs of identical bits. A run of sixteen equal bits, all ones or all zeros, means the loop has run away. The block then sends a one-cycle loop-reset strobe toward the analog loop and raises an overrange flag for one and a half sample periods. The run count starts again from zero after every loop reset.

Top module: `sdm_clk_supervisor`

## Requirements
- R1: While reset is asserted, the sample clock, overrange flag, loop-reset strobe and filter-clear strobe are all low.
- R2: With no sync edge and power-down low, the sample clock repeats every four master cycles: low for two, then high for two. It starts low after reset.
- R3: A sync rising edge seen at a master rising edge restarts the divider. The sample clock is low for the two cycles after that edge and high for the next two.
- R4: Only the low-to-high transition of sync counts. Holding sync high for many cycles acts exactly like a single pulse.
- R5: The filter-clear strobe is a one-cycle pulse in the cycle after a sync edge. It fires only if the divider was not already about to wrap, or if no sync has been taken since reset or power-down. A sync edge that finds the divider in its last phase, with the decimator already started, gives no strobe.
- R6: Power-down is sampled at master rising edges. In each cycle after an edge that saw it high, the sample clock is low and filter-clear is low. Sync edges that arrive during power-down are ignored.
- R7: After power-down ends, the first sync edge always produces a filter-clear strobe, even when the divider is in its last phase.
- R8: The modulator bit is sampled only at the master edge where the sample clock goes from high to low. Its value in other cycles has no effect.
- R9: When sixteen consecutive sampled bits are equal (ones or zeros), loop-reset is high for exactly one cycle, the cycle after the sixteenth sampling edge.
- R10: The overrange flag rises together with loop-reset and stays high for six master cycles, which is 1.5 sample periods.
- R11: The run count restarts after each loop reset, so a continuing run triggers again only after sixteen more equal samples. Any change in the bit restarts the count at one.
- R12: No samples are taken during power-down. A run interrupted by power-down continues counting after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, four times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Sync request; its rising edge re-phases the divider |
| pwrdn_i | input | 1 | Power-down request; holds the sample clock low |
| mod_bit_i | input | 1 | One-bit stream returned by the modulator |
| mod_clk_o | output | 1 | Sample clock to the modulator |
| ovr_flag_o | output | 1 | Overrange flag, high for 1.5 sample periods |
| loop_rst_o | output | 1 | One-cycle reset strobe toward the analog loop |
| filt_clr_o | output | 1 | One-cycle clear-and-start strobe for the decimator |

## Verification
A divider phase that is off by one shows up at once as a sample-clock edge one master cycle early or late. The same error moves every sampling point, so a run lands on a different loop-reset cycle within one sample period. A wrong run count, or a wrong record of the last bit, shows only after a run of up to sixteen samples (64 master cycles): a loop-reset arrives early, late or not at all. A lost "decimator not yet started" marker shows only at the next aligned sync, as a missing or extra filter-clear strobe.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // next divider phase, wrapping at the division ratio
  function automatic int phase_next(int ph, int div);
    return (ph + 1 >= div) ? 0 : ph + 1;
  endfunction

  // length of the identical-bit run after one more sample
  function automatic int run_next(int cnt, logic same);
    return (same && cnt != 0) ? cnt + 1 : 1;
  endfunction

  // overrange flag width in master cycles: one and a half sample periods
  function automatic int flag_cycles(int div);
    return (3 * div) / 2;
  endfunction

endpackage

// File: rtl/sdm_phase_gen.sv
module sdm_phase_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pwrdn_i,
  output logic mod_clk_o,
  output logic filt_clr_o,
  output logic sync_evt_o,
  output logic samp_tick_o
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          sync_prev_q;
  logic          need_start_q;
  logic          clk_q;
  logic          clr_q;
  logic          aligned;

  assign sync_evt_o  = sync_i & ~sync_prev_q & ~pwrdn_i;
  assign aligned     = (phase_q == LAST);
  assign samp_tick_o = ~pwrdn_i & aligned;

  always_comb begin
    if (pwrdn_i || sync_evt_o) phase_d = '0;
    else phase_d = PW'(sdm_pkg::phase_next(int'(phase_q), DIV));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= '0;
      sync_prev_q  <= 1'b0;
      need_start_q <= 1'b1;
      clk_q        <= 1'b0;
      clr_q        <= 1'b0;
    end else begin
      sync_prev_q <= sync_i;
      phase_q     <= phase_d;
      clk_q       <= (int'(phase_d) >= HALF);
      if (pwrdn_i) begin
        need_start_q <= 1'b1;
        clr_q        <= 1'b0;
      end else if (sync_evt_o) begin
        need_start_q <= 1'b0;
        clr_q        <= need_start_q | ~aligned;
      end else begin
        clr_q <= 1'b0;
      end
    end
  end

  assign mod_clk_o  = clk_q;
  assign filt_clr_o = clr_q;
endmodule

// File: rtl/sdm_run_detect.sv
module sdm_run_detect #(
  parameter int RUN_LEN = 16,
  localparam int RW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          samp_tick_i,
  input  logic          bit_i,
  output logic          hit_o,
  output logic          loop_rst_o,
  output logic [RW-1:0] run_len_o
);
  logic [RW-1:0] run_q, run_nxt;
  logic          last_q;
  logic          same;
  logic          lrst_q;

  assign same    = (bit_i == last_q);
  assign run_nxt = RW'(sdm_pkg::run_next(int'(run_q), same));
  assign hit_o   = samp_tick_i & (int'(run_nxt) == RUN_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      last_q <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      lrst_q <= hit_o;
      if (samp_tick_i) begin
        last_q <= bit_i;
        run_q  <= hit_o ? '0 : run_nxt;
      end
    end
  end

  assign loop_rst_o = lrst_q;
  assign run_len_o  = run_q;
endmodule

// File: rtl/sdm_flag_stretch.sv
module sdm_flag_stretch #(
  parameter int CYC = 6,
  localparam int FW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic flag_o
);
  logic [FW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else if (start_i) left_q <= FW'(CYC);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign flag_o = (left_q != '0);
endmodule

// File: rtl/sdm_clk_supervisor.sv
module sdm_clk_supervisor #(
  parameter int DIV     = 4,
  parameter int RUN_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic pwrdn_i,
  input  logic mod_bit_i,
  output logic mod_clk_o,
  output logic ovr_flag_o,
  output logic loop_rst_o,
  output logic filt_clr_o
);
  localparam int RW       = $clog2(RUN_LEN + 1);
  localparam int FLAG_CYC = sdm_pkg::flag_cycles(DIV);

  // internal events, named for the checker
  logic          sync_evt;
  logic          samp_tick;
  logic          run_hit;
  logic [RW-1:0] run_len;

  sdm_phase_gen #(.DIV(DIV)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .pwrdn_i    (pwrdn_i),
    .mod_clk_o  (mod_clk_o),
    .filt_clr_o (filt_clr_o),
    .sync_evt_o (sync_evt),
    .samp_tick_o(samp_tick)
  );

  sdm_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_tick_i(samp_tick),
    .bit_i      (mod_bit_i),
    .hit_o      (run_hit),
    .loop_rst_o (loop_rst_o),
    .run_len_o  (run_len)
  );

  sdm_flag_stretch #(.CYC(FLAG_CYC)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(run_hit),
    .flag_o (ovr_flag_o)
  );
endmodule

// File: rtl/sdm_clk_supervisor_chk.sv
module sdm_clk_supervisor_chk #(
  parameter int DIV     = 4,
  parameter int RUN_LEN = 16,
  localparam int RW = $clog2(RUN_LEN + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwrdn_i,
  input logic          mod_clk_o,
  input logic          ovr_flag_o,
  input logic          loop_rst_o,
  input logic          filt_clr_o,
  input logic          sync_evt,
  input logic          samp_tick,
  input logic [RW-1:0] run_len
);
  localparam int FLAG_CYC = (3 * DIV) / 2;

  logic [7:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt_q <= '0;
    else if (ovr_flag_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else hi_cnt_q <= '0;
  end

  assert_clk_high_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_clk_o) && !pwrdn_i && !sync_evt |=> mod_clk_o);

  assert_sync_rephase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt |=> !mod_clk_o);

  assert_clear_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_clr_o |=> !filt_clr_o);

  assert_pd_holds_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwrdn_i) |-> !mod_clk_o && !filt_clr_o);

  assert_sample_in_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_tick |-> mod_clk_o);

  assert_loop_rst_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_o |=> !loop_rst_o);

  assert_flag_with_rst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_o |-> ovr_flag_o);

  assert_flag_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_flag_o) |-> (int'(hi_cnt_q) == FLAG_CYC));

  assert_run_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_o |-> (run_len == '0));
endmodule

bind sdm_clk_supervisor sdm_clk_supervisor_chk #(.DIV(DIV), .RUN_LEN(RUN_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwrdn_i   (pwrdn_i),
  .mod_clk_o (mod_clk_o),
  .ovr_flag_o(ovr_flag_o),
  .loop_rst_o(loop_rst_o),
  .filt_clr_o(filt_clr_o),
  .sync_evt  (sync_evt),
  .samp_tick (samp_tick),
  .run_len   (run_len)
);

// File: tb/test_sdm_clk_supervisor.sv
module test_sdm_clk_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0, pd_in = 1'b0, bit_in = 1'b0;
  logic mod_clk, ovr_flag, loop_rst, filt_clr;

  int n_chk = 0, n_fail = 0;
  int lrst_seen = 0, fclr_seen = 0, hi_in_pd = 0;

  // bench model state, after the most recent rising edge
  int   m_pos = 0, m_run = 0, m_flag = 0;
  logic m_sp = 0, m_need = 1, m_last = 0, m_lrst = 0, m_fclr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_clk_supervisor i_sdm_clk_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_in), .pwrdn_i(pd_in),
    .mod_bit_i(bit_in), .mod_clk_o(mod_clk), .ovr_flag_o(ovr_flag),
    .loop_rst_o(loop_rst), .filt_clr_o(filt_clr));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_clk(int pos);
    return pos >= 2;
  endfunction

  // advance the model over the coming rising edge, given the driven inputs
  task automatic advance(logic s, logic p, logic b);
    logic edge_s, tick, hit;
    int n;
    edge_s = s && !m_sp && !p;
    m_sp = s;
    tick = !p && (m_pos == 3);
    hit = 1'b0;
    if (tick) begin
      n = (m_run != 0 && b == m_last) ? m_run + 1 : 1;
      m_last = b;
      if (n == 16) begin hit = 1'b1; m_run = 0; end
      else m_run = n;
    end
    if (hit) m_flag = 6; else if (m_flag > 0) m_flag--;
    m_lrst = hit;
    if (p) begin m_pos = 0; m_need = 1; m_fclr = 0; end
    else if (edge_s) begin m_fclr = m_need || (m_pos != 3); m_need = 0; m_pos = 0; end
    else begin m_pos = (m_pos + 1) % 4; m_fclr = 0; end
  endtask

  // one master cycle: check at the falling edge, then drive for the next rising edge
  task automatic cyc(logic s, logic p, logic b);
    @(negedge clk);
    chk("R2 sample clock", int'(mod_clk), int'(exp_clk(m_pos)));
    chk("R10 overrange flag", int'(ovr_flag), int'(m_flag != 0));
    chk("R9 loop reset", int'(loop_rst), int'(m_lrst));
    chk("R5 filter clear", int'(filt_clr), int'(m_fclr));
    if (loop_rst) lrst_seen++;
    if (filt_clr) fclr_seen++;
    sync_in = s; pd_in = p; bit_in = b;
    advance(s, p, b);
  endtask

  task automatic sample_bits(logic b, int count);
    int k = 0;
    while (k < count) begin
      if (m_pos == 3) k++;
      cyc(1'b0, 1'b0, b);
    end
  endtask

  task automatic wait_pos(int pos);
    while (m_pos != pos) cyc(1'b0, 1'b0, bit_in);
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk("R1 clk", int'(mod_clk), 0);
    chk("R1 flag", int'(ovr_flag), 0);
    chk("R1 loop_rst", int'(loop_rst), 0);
    chk("R1 filt_clr", int'(filt_clr), 0);
    rst_n = 1'b1;
    advance(1'b0, 1'b0, 1'b1);
    bit_in = 1'b1;
    repeat (12) cyc(1'b0, 1'b0, 1'b1);

    // R3 / R5: first sync after reset clears
    base = fclr_seen;
    wait_pos(1);
    cyc(1'b1, 1'b0, 1'b1);
    repeat (6) cyc(1'b0, 1'b0, 1'b1);
    chk("R5 first sync clears", fclr_seen - base, 1);

    // R4: held sync acts once
    wait_pos(1);
    base = fclr_seen;
    repeat (20) cyc(1'b1, 1'b0, 1'b1);
    repeat (4) cyc(1'b0, 1'b0, 1'b1);
    chk("R4 held sync single", fclr_seen - base, 1);

    // R5: aligned sync with decimator started gives no clear
    wait_pos(3);
    base = fclr_seen;
    cyc(1'b1, 1'b0, 1'b1);
    repeat (6) cyc(1'b0, 1'b0, 1'b1);
    chk("R5 aligned sync no clear", fclr_seen - base, 0);

    // R6: power-down holds clock low, sync ignored
    base = fclr_seen;
    hi_in_pd = 0;
    cyc(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 24; i++) begin
      cyc(i[2], 1'b1, 1'b1);
      if (mod_clk) hi_in_pd++;
    end
    chk("R6 clock low in power-down", hi_in_pd, 0);
    chk("R6 sync ignored in power-down", fclr_seen - base, 0);

    // R7: first sync after release clears even when aligned
    cyc(1'b0, 1'b0, 1'b1);
    wait_pos(3);
    base = fclr_seen;
    cyc(1'b1, 1'b0, 1'b1);
    repeat (4) cyc(1'b0, 1'b0, 1'b1);
    chk("R7 sync after power-down clears", fclr_seen - base, 1);

    // R9: sixteen ones, then sixteen zeros
    sample_bits(1'b0, 1);
    base = lrst_seen;
    sample_bits(1'b1, 16);
    repeat (3) cyc(1'b0, 1'b0, 1'b1);
    chk("R9 sixteen ones", lrst_seen - base, 1);
    base = lrst_seen;
    sample_bits(1'b0, 16);
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    chk("R9 sixteen zeros", lrst_seen - base, 1);

    // R11: fifteen then a change does not trigger; continuing run retriggers
    base = lrst_seen;
    sample_bits(1'b1, 15);
    sample_bits(1'b0, 1);
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    chk("R11 change restarts count", lrst_seen - base, 0);
    base = lrst_seen;
    sample_bits(1'b1, 48);
    repeat (3) cyc(1'b0, 1'b0, 1'b1);
    chk("R11 continuing run retriggers", lrst_seen - base, 3);

    // R8: bit only matters at the sampling edge
    sample_bits(1'b0, 1);
    base = lrst_seen;
    for (int k = 0; k < 16; ) begin
      if (m_pos == 3) begin k++; cyc(1'b0, 1'b0, 1'b1); end
      else cyc(1'b0, 1'b0, 1'b0);
    end
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    chk("R8 sampled only at falling sample clock", lrst_seen - base, 1);

    // R12: run frozen through power-down
    sample_bits(1'b1, 1);
    base = lrst_seen;
    sample_bits(1'b0, 10);
    repeat (30) cyc(1'b0, 1'b1, 1'b1);
    sample_bits(1'b0, 6);
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    chk("R12 run resumes after power-down", lrst_seen - base, 1);

    // random stimulus against the model
    begin
      logic s = 0, p = 0, b = 0;
      for (int i = 0; i < 6000; i++) begin
        int flip_div = ((i / 500) % 2 == 0) ? 24 : 200;
        if (p) begin if ($urandom % 16 == 0) p = 0; end
        else if ($urandom % 150 == 0) p = 1;
        if ($urandom % 12 == 0) s = ~s;
        if ($urandom % flip_div == 0) b = ~b;
        cyc(s, p, b);
      end
    end
    cyc(1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule